// File: doc/BRIEF.md
# Delayed-Write Store Cache Front End

This block is a direct-mapped, one-word-per-line data cache whose stores never need two back-to-back cycles on the data array. A store checks its tag in the cycle it arrives. When it hits, its index and data are parked in a single pending-write register. The data array is then written in the following cycle, while the next request is being looked up. Loads compare their index with the pending register. When the pending entry covers the loaded line, a late multiplexer returns the parked data in place of the stale array word.

The cache is write-through with no allocation on a write. Every store, hit or miss, leaves on a write-through port one cycle later. A store that misses raises a miss flag and leaves the cache unchanged. Lines are installed by a plain refill port. An outside agent drives it in cycles that carry no request, and it writes the tag, the valid bit and the data word together. The data array has one write port and one synchronous read port, so it maps onto a single block RAM.

Top module: `dwb_store_cache`

## Requirements
- R1: After reset, resp_valid, resp_hit, store_miss and wt_valid are 0, and every line is invalid, so the first load to any address misses.
- R2: A load presented with req_valid=1 and req_store=0 gives resp_valid=1 one cycle later. resp_hit=1 only if the line at index req_addr[IDX_W-1:0] is valid and holds tag req_addr[ADDR_W-1:IDX_W]. On a miss resp_rdata is 0.
- R3: A load that hits returns the most recent data stored to that address. This includes a store in the cycle just before the load, whose data is still in the pending register.
- R4: A store that hits gives resp_valid=1, resp_hit=1 and store_miss=0 one cycle later, and its data becomes visible to later loads of that address.
- R5: A store that misses gives resp_valid=1, resp_hit=0 and store_miss=1 one cycle later. It changes neither the tag nor the data of the line, so a load of the address held there still returns that address's data.
- R6: Every store, hit or miss, appears one cycle later on wt_valid/wt_addr/wt_data with its address and data. wt_valid is 0 one cycle after any cycle without a store.
- R7: Consecutive stores that hit, to the same line or to different lines, are all kept: the older pending write reaches the array before the newer one replaces it, and the last store wins.
- R8: A refill (fill_valid=1) makes the line at fill_addr's index valid with fill_addr's tag and data fill_data. Refill cycles and idle cycles produce no response and no write-through.
- R9: A refill to the index of a still-pending store write discards that write, so the line holds only the refill data. A refill to another index leaves the pending write intact.
- R10: fill_valid is only asserted in cycles with req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| fill_valid | input | 1 | Refill a line this cycle |
| fill_addr | input | ADDR_W | Word address being refilled |
| fill_data | input | DATA_W | Refill data |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_hit | output | 1 | That request hit |
| resp_rdata | output | DATA_W | Load data, 0 on a miss or store |
| store_miss | output | 1 | The previous cycle's store missed |
| wt_valid | output | 1 | Write-through word valid |
| wt_addr | output | ADDR_W | Write-through address |
| wt_data | output | DATA_W | Write-through data |

## Verification
The hardest case to reach from the ports is a refill that lands on the index of a pending write, because a pending write lives for only one cycle unless a refill holds it. The stimulus first stores to one address so that the store hits. In the very next cycle it refills the same index with a different tag. It then loads both the new and the old address, to show that the parked data did not land on top of the new line. Forwarding is reached the same way, with a load issued in the cycle right after a store to the same address. A long random run over three tags that collide on sixteen indices mixes stores, loads, refills and idles. Every output is compared on every clock against a flat reference memory plus a tag table kept in the bench.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  // One operation is taken per cycle; a refill wins over a request.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_FILL  = 2'd3
  } dwb_op_e;
endpackage

// File: rtl/dwb_tag_store.sv
module dwb_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             hit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]            line_v;
  logic [DEPTH-1:0][TAG_W-1:0] line_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_v <= '0;
    end else if (wr_en) begin
      line_v[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) line_tag[wr_idx] <= wr_tag;
  end

  assign hit = line_v[lk_idx] && (line_tag[lk_idx] == lk_tag);

  // A refilled line answers a lookup of the same index and tag in the next cycle.
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lk_idx == wr_idx && lk_tag == wr_tag) |=> ($past(lk_idx) != lk_idx || $past(lk_tag) != lk_tag || hit)); // R8
endmodule

// File: rtl/dwb_data_ram.sv
module dwb_data_ram #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single-clock RAM: a read of the address written in the
  // same cycle returns the old word.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dwb_pending.sv
module dwb_pending
  import dwb_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  dwb_op_e           op,
  input  logic              hit,
  input  logic [IDX_W-1:0]  op_idx,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              pend_v,
  output logic [IDX_W-1:0]  pend_idx,
  output logic [DATA_W-1:0] pend_data,
  output logic              drain_en
);
  // The array port is free in every cycle except a refill.
  assign drain_en = pend_v && (op != OP_FILL);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
    end else begin
      unique case (op)
        OP_STORE: pend_v <= hit;
        OP_FILL:  if (op_idx == pend_idx) pend_v <= 1'b0;
        default:  pend_v <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == OP_STORE && hit) begin
      pend_idx  <= op_idx;
      pend_data <= op_wdata;
    end
  end

  AST_PEND_FROM_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_v) |-> $past(op == OP_STORE && hit)); // R4
  AST_FILL_CANCELS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FILL && pend_v && op_idx == pend_idx) |=> !pend_v); // R9
  AST_FILL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FILL && pend_v && op_idx != pend_idx) |=> (pend_v && $stable(pend_data))); // R9
endmodule

// File: rtl/dwb_store_cache.sv
module dwb_store_cache
  import dwb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              store_miss,
  output logic              wt_valid,
  output logic [ADDR_W-1:0] wt_addr,
  output logic [DATA_W-1:0] wt_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  dwb_op_e           op;
  logic [ADDR_W-1:0] op_addr;
  logic [IDX_W-1:0]  op_idx;
  logic [TAG_W-1:0]  op_tag;
  logic              hit;
  logic              pend_v;
  logic [IDX_W-1:0]  pend_idx;
  logic [DATA_W-1:0] pend_data;
  logic              drain_en;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_q;
  logic              ld_hit_q;
  logic              fwd_q;
  logic [DATA_W-1:0] fwd_data_q;

  always_comb begin
    if (fill_valid)     op = OP_FILL;
    else if (!req_valid) op = OP_IDLE;
    else if (req_store) op = OP_STORE;
    else                op = OP_LOAD;
  end

  assign op_addr = fill_valid ? fill_addr : req_addr;
  assign op_idx  = op_addr[IDX_W-1:0];
  assign op_tag  = op_addr[ADDR_W-1:IDX_W];

  dwb_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .lk_idx (op_idx),
    .lk_tag (op_tag),
    .wr_en  (op == OP_FILL),
    .wr_idx (op_idx),
    .wr_tag (op_tag),
    .hit    (hit)
  );

  dwb_pending #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .hit       (hit),
    .op_idx    (op_idx),
    .op_wdata  (req_wdata),
    .pend_v    (pend_v),
    .pend_idx  (pend_idx),
    .pend_data (pend_data),
    .drain_en  (drain_en)
  );

  // Single write port: a refill owns it, otherwise the pending write drains.
  assign ram_we    = (op == OP_FILL) || drain_en;
  assign ram_waddr = (op == OP_FILL) ? op_idx : pend_idx;
  assign ram_wdata = (op == OP_FILL) ? fill_data : pend_data;

  dwb_data_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (op_idx),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      store_miss <= 1'b0;
      wt_valid   <= 1'b0;
      ld_hit_q   <= 1'b0;
      fwd_q      <= 1'b0;
    end else begin
      resp_valid <= (op == OP_LOAD) || (op == OP_STORE);
      resp_hit   <= ((op == OP_LOAD) || (op == OP_STORE)) && hit;
      store_miss <= (op == OP_STORE) && !hit;
      wt_valid   <= (op == OP_STORE);
      ld_hit_q   <= (op == OP_LOAD) && hit;
      fwd_q      <= (op == OP_LOAD) && hit && pend_v && (pend_idx == op_idx);
    end
  end

  always_ff @(posedge clk) begin
    fwd_data_q <= pend_data;
    if (op == OP_STORE) begin
      wt_addr <= req_addr;
      wt_data <= req_wdata;
    end
  end

  // Late bypass: parked store data overrides the array word it has not reached yet.
  always_comb begin
    if (!ld_hit_q)  resp_rdata = '0;
    else if (fwd_q) resp_rdata = fwd_data_q;
    else            resp_rdata = ram_q;
  end

  AST_FILL_IDLE: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> !req_valid); // R10
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !fill_valid) |=> resp_valid); // R2
  AST_WT_EACH_STORE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && !fill_valid) |=> (wt_valid && wt_addr == $past(req_addr) && wt_data == $past(req_wdata))); // R6
  AST_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
    store_miss |-> (resp_valid && !resp_hit)); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> (resp_rdata == '0)); // R2
endmodule

// File: tb/test_dwb_store_cache.sv
`timescale 1ns/1ps
module test_dwb_store_cache;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int MWORDS = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_store = 1'b0, fill_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0, fill_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, fill_data = '0;
  logic resp_valid, resp_hit, store_miss, wt_valid;
  logic [DATA_W-1:0] resp_rdata, wt_data;
  logic [ADDR_W-1:0] wt_addr;

  always #2 clk = ~clk;

  dwb_store_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_dwb_store_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr), .req_wdata(req_wdata),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .store_miss(store_miss), .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data)
  );

  // Reference: flat lower-level memory plus a tag table.
  logic [DATA_W-1:0] ref_mem [MWORDS];
  logic              ref_v   [DEPTH];
  logic [TAG_W-1:0]  ref_tag [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_hit(input logic [ADDR_W-1:0] a);
    return ref_v[a[IDX_W-1:0]] && ref_tag[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W];
  endfunction

  task automatic check_quiet(input string req);
    chk(resp_valid == 1'b0, {req, " resp_valid"}, 32'(resp_valid), 0);
    chk(wt_valid == 1'b0,   {req, " wt_valid"},   32'(wt_valid), 0);
    chk(store_miss == 1'b0, {req, " store_miss"}, 32'(store_miss), 0);
  endtask

  task automatic do_idle();
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    @(posedge clk); #1;
    check_quiet("R8 idle");
  endtask

  task automatic do_fill(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b1; fill_addr = a; fill_data = ref_mem[a];
    ref_v[a[IDX_W-1:0]] = 1'b1;
    ref_tag[a[IDX_W-1:0]] = a[ADDR_W-1:IDX_W];
    @(posedge clk); #1;
    check_quiet("R8 fill");
  endtask

  task automatic do_load(input logic [ADDR_W-1:0] a, input string req);
    bit eh;
    logic [DATA_W-1:0] ed;
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b1; req_store = 1'b0; req_addr = a;
    eh = ref_hit(a);
    ed = eh ? ref_mem[a] : '0;
    @(posedge clk); #1;
    chk(resp_valid == 1'b1, {req, " R2 resp_valid"}, 32'(resp_valid), 1);
    chk(resp_hit == eh,     {req, " R2 resp_hit"},   32'(resp_hit), 32'(eh));
    chk(resp_rdata == ed,   {req, " R3 rdata"},      resp_rdata, ed);
    chk(wt_valid == 1'b0,   {req, " R6 wt_valid"},   32'(wt_valid), 0);
  endtask

  task automatic do_store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string req);
    bit eh;
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b1; req_store = 1'b1; req_addr = a; req_wdata = d;
    eh = ref_hit(a);
    ref_mem[a] = d;
    @(posedge clk); #1;
    chk(resp_valid == 1'b1, {req, " R4 resp_valid"}, 32'(resp_valid), 1);
    chk(resp_hit == eh,     {req, " R4 resp_hit"},   32'(resp_hit), 32'(eh));
    chk(store_miss == !eh,  {req, " R5 store_miss"}, 32'(store_miss), 32'(!eh));
    chk(wt_valid == 1'b1,   {req, " R6 wt_valid"},   32'(wt_valid), 1);
    chk(wt_addr == a,       {req, " R6 wt_addr"},    32'(wt_addr), 32'(a));
    chk(wt_data == d,       {req, " R6 wt_data"},    wt_data, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MWORDS; i++) ref_mem[i] = 32'h1000_0000 + i * 7;
    for (int i = 0; i < DEPTH; i++) begin ref_v[i] = 1'b0; ref_tag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check_quiet("R1 reset");
    chk(resp_hit == 1'b0, "R1 resp_hit", 32'(resp_hit), 0);
    do_load(10'd5, "R1 cold");
    do_load(10'd300, "R1 cold");
    do_store(10'd9, 32'h0, "R1 cold store");
    // R8 refill then hit
    do_fill(10'd5);
    do_load(10'd5, "R8 after fill");
    // R3 forwarding from a just-parked store
    do_store(10'd5, 32'hAAAA_0001, "R3 store");
    do_load(10'd5, "R3 forward");
    do_idle();
    do_load(10'd5, "R3 drained");
    // R7 consecutive stores, same line and different lines
    do_fill(10'd6);
    do_store(10'd5, 32'h0000_0011, "R7 s1");
    do_store(10'd5, 32'h0000_0022, "R7 s2");
    do_store(10'd6, 32'h0000_0033, "R7 s3");
    do_load(10'd5, "R7 last wins");
    do_load(10'd6, "R7 other line");
    // R5 store miss to a colliding tag leaves line untouched
    do_store(10'd21, 32'hDEAD_0005, "R5 miss");
    do_load(10'd5, "R5 line kept");
    do_load(10'd21, "R5 still miss");
    // R9 refill to index of a pending write
    do_store(10'd5, 32'hBEEF_0005, "R9 park");
    do_fill(10'd21);
    do_load(10'd21, "R9 refill data");
    do_load(10'd5, "R9 old tag gone");
    // R9 refill to another index keeps the pending write
    do_store(10'd6, 32'hCAFE_0006, "R9 park2");
    do_fill(10'd7);
    do_load(10'd6, "R9 pending kept");
    do_load(10'd7, "R9 other fill");
    // Mixed random traffic over colliding tags
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] a;
      int k;
      a = {TAG_W'($urandom_range(0, 2)), IDX_W'($urandom_range(0, DEPTH - 1))};
      k = $urandom_range(0, 9);
      if (k < 4)      do_store(a, $urandom(), "R7 rnd store");
      else if (k < 8) do_load(a, "R3 rnd load");
      else if (k < 9) do_fill(a);
      else            do_idle();
    end
    do_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule